// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block governs the transmit side of a half-duplex Ethernet MAC once a frame is ready to go. It waits for the medium to fall quiet, asks the transmitter to send, and watches for collisions while the frame goes out. After a collision it decides what comes next. An early collision leads to a jam and then a retry, either at once or after a random backoff counted in slot times. A late collision drops the frame with a flag. When the retry budget is spent, the frame is aborted. A frame that defers to carrier sense for too long is aborted or sent anyway, depending on a policy input.

Timing follows the byte strobe of the transmit path. Bytes are counted from the first byte of the attempt, preamble included, and that count is compared against a programmable collision window. A 10-bit LFSR runs on every clock and is sampled at the moment of a collision to pick the backoff. All configuration arrives on plain input ports. Suggested power-up values are: backoff enabled, deferral allowed, retry limit 15, window 55.

The state machine has five states. `S_IDLE` waits for `tx_start` and goes to `S_DEFER`. `S_DEFER` goes to `S_XMIT` when carrier sense is low (`send_req` pulses). It goes to `S_IDLE` on excessive deferral when the policy forbids it. `S_XMIT` goes to `S_IDLE` on `tx_end` or on a late collision, and to `S_JAM` on an early collision. `S_JAM` goes, after four strobes, to `S_IDLE` when the retry limit is exceeded, to `S_DEFER` when backoff is bypassed, and otherwise to `S_BACKOFF`. `S_BACKOFF` goes to `S_DEFER` when the slot countdown reaches zero.

Top module: `hd_retry_ctrl`

## Requirements
- R1: After reset all four outputs are low and the block is idle. A `tx_start` pulse while carrier sense is low gives a one-cycle `send_req` in the next cycle.
- R2: While a frame waits in `S_DEFER` with carrier sense high, byte strobes are counted. With `cfg_defer_allow`=0, `abort_xdefer` pulses on the 3037th such strobe and the block returns to idle without sending.
- R3: With `cfg_defer_allow`=1, a deferral of any length gives no abort, and `send_req` pulses in the first cycle in which carrier sense is seen low.
- R4: Byte strobes are counted from the start of an attempt. A collision with the count less than or equal to `cfg_col_window` is early and takes the retry path. A collision with the count above it pulses `late_col` for one cycle and ends the frame with no retry.
- R5: Every early collision is followed by a jam of 4 byte strobes. With `cfg_no_backoff`=1, jam end leads straight to deferral, so with continuous strobes and carrier low `send_req` comes 5 cycles after the collision cycle.
- R6: With `cfg_no_backoff`=0, after collision n the wait is r slot times of 64 strobes, with 0 <= r < 2^min(n,10). With continuous strobes and carrier low, `send_req` comes 6+64r cycles after the collision cycle.
- R7: The attempt count n counts the early collisions of the current frame. When n exceeds `cfg_retry_max`, `abort_xcol` pulses in the last jam cycle (4 cycles after the collision) and no retry follows. A limit of 0 aborts on the first collision.
- R8: The attempt count returns to 0 when a frame ends, whether by `tx_end`, by a late collision or by either abort.
- R9: At most one of `send_req`, `abort_xcol`, `abort_xdefer` and `late_col` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | A frame is ready; sampled in idle |
| tx_end | input | 1 | Current attempt finished without collision |
| byte_stb | input | 1 | One byte time on the transmit path |
| col_det | input | 1 | Collision detected |
| crs | input | 1 | Carrier sense |
| cfg_no_backoff | input | 1 | 1: retry right after jam, no random wait |
| cfg_defer_allow | input | 1 | 1: send after excessive deferral; 0: abort |
| cfg_retry_max | input | 4 | Retransmissions allowed after collisions |
| cfg_col_window | input | 6 | Collision window end, in bytes from attempt start |
| send_req | output | 1 | Pulse: start sending an attempt now |
| abort_xcol | output | 1 | Pulse: frame dropped, too many collisions |
| abort_xdefer | output | 1 | Pulse: frame dropped, deferred too long |
| late_col | output | 1 | Pulse: collision after the window, frame dropped |

## Verification
The hardest case to reach is the excessive-collision abort under the default limit, which needs sixteen early collisions in one frame. The bench gets there quickly with the backoff bypass turned on, so each retry costs five cycles instead of a random number of slots. Attempt-count reset is made visible through the ports: a frame that ends in a late collision with a limit of 1 is followed by a frame whose first collision must still retry, not abort. The random backoff is checked by range and slot granularity for the first three attempts, since the exact LFSR draw is not modelled.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DEFER,
        S_XMIT,
        S_JAM,
        S_BACKOFF
    } hdr_state_e;
endpackage

// File: rtl/hdr_lfsr.sv
module hdr_lfsr #(
    parameter int W   = 10,
    parameter int TAP = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    logic fb;
    assign fb = q[W-1] ^ q[TAP-1];

    always_ff @(posedge clk) begin
        if (!rst_n) q <= W'(1);
        else        q <= {q[W-2:0], fb};
    end

    assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/hdr_slot_timer.sv
module hdr_slot_timer #(
    parameter int SLOT_BYTES = 64,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_slots,
    input  logic             run,
    input  logic             byte_stb,
    output logic             zero
);
    localparam int SB_W = $clog2(SLOT_BYTES);

    logic [SB_W-1:0]  byte_in_slot;
    logic [CNT_W-1:0] slots_left;

    assign zero = (slots_left == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_in_slot <= '0;
            slots_left   <= '0;
        end else if (load) begin
            byte_in_slot <= '0;
            slots_left   <= load_slots;
        end else if (run && byte_stb && !zero) begin
            if (byte_in_slot == SB_W'(SLOT_BYTES - 1)) begin
                byte_in_slot <= '0;
                slots_left   <= slots_left - CNT_W'(1);
            end else begin
                byte_in_slot <= byte_in_slot + SB_W'(1);
            end
        end
    end

    assert_slot_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && byte_stb && !zero && byte_in_slot == SB_W'(SLOT_BYTES - 1))
        |=> slots_left == $past(slots_left) - CNT_W'(1));
endmodule

// File: rtl/hd_retry_ctrl.sv
module hd_retry_ctrl #(
    parameter int RETRY_W     = 4,
    parameter int WIN_W       = 6,
    parameter int LFSR_W      = 10,
    parameter int LFSR_TAP    = 7,
    parameter int SLOT_BYTES  = 64,
    parameter int JAM_BYTES   = 4,
    parameter int DEFER_LIMIT = 3036
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_start,
    input  logic               tx_end,
    input  logic               byte_stb,
    input  logic               col_det,
    input  logic               crs,
    input  logic               cfg_no_backoff,
    input  logic               cfg_defer_allow,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    input  logic [WIN_W-1:0]   cfg_col_window,
    output logic               send_req,
    output logic               abort_xcol,
    output logic               abort_xdefer,
    output logic               late_col
);
    import hdr_pkg::*;

    localparam int ATT_W = RETRY_W + 1;
    localparam int BC_W  = WIN_W + 1;
    localparam int DEF_W = $clog2(DEFER_LIMIT + 1);
    localparam int JAM_W = $clog2(JAM_BYTES);

    hdr_state_e        state, next_state;
    logic [ATT_W-1:0]  attempts, attempts_nxt;
    logic [BC_W-1:0]   byte_cnt;
    logic [DEF_W-1:0]  defer_cnt;
    logic [JAM_W-1:0]  jam_cnt;
    logic [LFSR_W-1:0] rnd, bo_mask;
    logic              defer_hit, late_hit, jam_last, over_limit, early_col, bo_zero;

    hdr_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .q(rnd)
    );

    hdr_slot_timer #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(LFSR_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .load(early_col), .load_slots(rnd & bo_mask),
        .run(state == S_BACKOFF), .byte_stb(byte_stb), .zero(bo_zero)
    );

    assign defer_hit    = byte_stb && (defer_cnt == DEF_W'(DEFER_LIMIT));
    assign late_hit     = byte_cnt > {1'b0, cfg_col_window};
    assign jam_last     = byte_stb && (jam_cnt == JAM_W'(JAM_BYTES - 1));
    assign over_limit   = attempts > {1'b0, cfg_retry_max};
    assign early_col    = (state == S_XMIT) && col_det && !late_hit;
    assign attempts_nxt = attempts + ATT_W'(1);

    // backoff range mask: 2^min(n,LFSR_W)-1 for attempt n
    always_comb begin
        for (int i = 0; i < LFSR_W; i++) bo_mask[i] = (i < int'(attempts_nxt));
    end

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:    if (tx_start) next_state = S_DEFER;
            S_DEFER:   if (!crs) next_state = S_XMIT;
                       else if (defer_hit && !cfg_defer_allow) next_state = S_IDLE;
            S_XMIT:    if (col_det) next_state = late_hit ? S_IDLE : S_JAM;
                       else if (tx_end) next_state = S_IDLE;
            S_JAM:     if (jam_last) next_state = over_limit ? S_IDLE :
                                     (cfg_no_backoff ? S_DEFER : S_BACKOFF);
            S_BACKOFF: if (bo_zero) next_state = S_DEFER;
            default:   next_state = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    // counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attempts  <= '0;
            byte_cnt  <= '0;
            defer_cnt <= '0;
            jam_cnt   <= '0;
        end else begin
            if (next_state == S_IDLE) attempts <= '0;
            else if (early_col)       attempts <= attempts_nxt;

            if (state != S_XMIT)                 byte_cnt <= '0;
            else if (byte_stb && byte_cnt != '1) byte_cnt <= byte_cnt + BC_W'(1);

            if (state != S_DEFER) defer_cnt <= '0;
            else if (byte_stb && crs && defer_cnt != DEF_W'(DEFER_LIMIT))
                defer_cnt <= defer_cnt + DEF_W'(1);

            if (state != S_JAM) jam_cnt <= '0;
            else if (byte_stb)  jam_cnt <= jam_cnt + JAM_W'(1);
        end
    end

    // outputs
    always_comb begin
        send_req     = (state == S_DEFER) && !crs;
        abort_xdefer = (state == S_DEFER) && crs && defer_hit && !cfg_defer_allow;
        late_col     = (state == S_XMIT) && col_det && late_hit;
        abort_xcol   = (state == S_JAM) && jam_last && over_limit;
    end

    assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_req, abort_xcol, abort_xdefer, late_col}));

    assert_send_enters_xmit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |=> (state == S_XMIT) && (byte_cnt == '0));

    assert_defer_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        defer_cnt <= DEF_W'(DEFER_LIMIT));

    assert_late_ends_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        late_col |=> (state == S_IDLE) && (attempts == '0));

    assert_early_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        early_col |=> (state == S_JAM) && (attempts == $past(attempts) + ATT_W'(1)));

    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_xcol || abort_xdefer) |=> (state == S_IDLE) && (attempts == '0));
endmodule

// File: tb/hd_retry_ctrl_tb.sv
module hd_retry_ctrl_tb;
    localparam int EV_SEND = 0, EV_XCOL = 1, EV_XDEF = 2, EV_LATE = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_start = 0, tx_end = 0, byte_stb = 0, col_det = 0, crs = 0;
    logic cfg_no_backoff = 0, cfg_defer_allow = 1;
    logic [3:0] cfg_retry_max = 4'd15;
    logic [5:0] cfg_col_window = 6'd55;
    logic send_req, abort_xcol, abort_xdefer, late_col;

    int checks = 0, errors = 0;
    bit done = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    hd_retry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
        .byte_stb(byte_stb), .col_det(col_det), .crs(crs),
        .cfg_no_backoff(cfg_no_backoff), .cfg_defer_allow(cfg_defer_allow),
        .cfg_retry_max(cfg_retry_max), .cfg_col_window(cfg_col_window),
        .send_req(send_req), .abort_xcol(abort_xcol),
        .abort_xdefer(abort_xdefer), .late_col(late_col)
    );

    function automatic string tag(int ev);
        case (ev)
            EV_SEND: return "R1/R5/R6";
            EV_XCOL: return "R7";
            EV_XDEF: return "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compare every output event against the expected queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n, ev;
            n = int'(send_req) + int'(abort_xcol) + int'(abort_xdefer) + int'(late_col);
            if (n > 1) check(0, "R9 one event per cycle", n, 1);
            if (n == 1) begin
                ev = send_req ? EV_SEND : abort_xcol ? EV_XCOL : abort_xdefer ? EV_XDEF : EV_LATE;
                if (exp_q.size() == 0) check(0, {tag(ev), " unexpected event"}, ev, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(e == ev, {tag(e), " event kind"}, ev, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_frame();
        exp_q.push_back(EV_SEND);
        tx_start = 1; tick(); tx_start = 0;
        tick();
    endtask

    task automatic send_bytes(int k);
        byte_stb = 1; repeat (k) tick(); byte_stb = 0;
    endtask

    task automatic finish_frame();
        tx_end = 1; tick(); tx_end = 0;
    endtask

    // collide now; measure cycles from collision cycle to send_req or abort_xcol
    task automatic collide(output int d);
        col_det = 1; byte_stb = 0; tick();
        col_det = 0; byte_stb = 1; d = 1;
        forever begin
            @(negedge clk);
            if (send_req || abort_xcol) break;
            @(posedge clk); #1; d++;
        end
        @(posedge clk); #1; byte_stb = 0;
    endtask

    task automatic late_hit();
        exp_q.push_back(EV_LATE);
        col_det = 1;
        @(negedge clk);
        check(late_col == 1'b1, "R4 late collision flag", int'(late_col), 1);
        tick(); col_det = 0;
    endtask

    initial begin
        int d, r;
        repeat (3) tick();
        @(negedge clk);
        check({send_req, abort_xcol, abort_xdefer, late_col} == 4'b0, "R1 reset outputs",
              int'({send_req, abort_xcol, abort_xdefer, late_col}), 0);
        tick(); rst_n = 1; tick();

        // R1 plain frame
        start_frame(); send_bytes(100); finish_frame(); repeat (3) tick();
        check(exp_q.size() == 0, "R1 send seen", exp_q.size(), 0);

        // R6 backoff ranges for attempts 1..3, first at window boundary (R4 early)
        start_frame(); send_bytes(55);
        for (int n = 1; n <= 3; n++) begin
            exp_q.push_back(EV_SEND);
            collide(d);
            r = (d - 6) / 64;
            check(d >= 6 && (d - 6) % 64 == 0, "R6 slot granularity", d, 6 + 64 * r);
            check(r < (1 << n), "R6 backoff range", r, (1 << n) - 1);
        end
        finish_frame(); repeat (2) tick();

        // R5 bypass, R7 limit 2
        cfg_no_backoff = 1; cfg_retry_max = 4'd2;
        start_frame(); send_bytes(2);
        for (int n = 1; n <= 2; n++) begin
            exp_q.push_back(EV_SEND); collide(d);
            check(d == 5, "R5 immediate retry", d, 5);
        end
        exp_q.push_back(EV_XCOL); collide(d);
        check(d == 4, "R7 abort after limit", d, 4);
        repeat (10) tick();
        check(exp_q.size() == 0, "R7 no retry after abort", exp_q.size(), 0);

        // R7 limit 0
        cfg_retry_max = 4'd0;
        start_frame(); exp_q.push_back(EV_XCOL); collide(d);
        check(d == 4, "R7 limit zero aborts first", d, 4);
        repeat (3) tick();

        // R7 default limit 15: 15 retries, 16th collision aborts
        cfg_retry_max = 4'd15;
        start_frame();
        for (int n = 1; n <= 15; n++) begin
            exp_q.push_back(EV_SEND); collide(d);
            check(d == 5, "R7 retry within limit", d, 5);
        end
        exp_q.push_back(EV_XCOL); collide(d);
        check(d == 4, "R7 sixteenth collision aborts", d, 4);
        repeat (3) tick();

        // R8 attempt count cleared by late collision
        cfg_retry_max = 4'd1;
        start_frame(); send_bytes(5);
        exp_q.push_back(EV_SEND); collide(d);
        check(d == 5, "R8 first retry", d, 5);
        send_bytes(60); late_hit(); repeat (3) tick();
        start_frame(); send_bytes(5);
        exp_q.push_back(EV_SEND); collide(d);
        check(d == 5, "R8 count reset after late collision", d, 5);
        finish_frame(); repeat (3) tick();

        // R4 window 3: 3 bytes early, 4 bytes late
        cfg_col_window = 6'd3; cfg_retry_max = 4'd15;
        start_frame(); send_bytes(3);
        exp_q.push_back(EV_SEND); collide(d);
        check(d == 5, "R4 collision at window end is early", d, 5);
        send_bytes(4); late_hit(); repeat (3) tick();
        cfg_col_window = 6'd55;

        // R2 excessive deferral aborts on strobe 3037
        cfg_defer_allow = 0; crs = 1;
        exp_q.push_back(EV_XDEF);
        tx_start = 1; tick(); tx_start = 0; byte_stb = 1;
        d = 0;
        for (int k = 1; k <= 3100; k++) begin
            @(negedge clk);
            if (abort_xdefer && d == 0) d = k;
            @(posedge clk); #1;
        end
        byte_stb = 0; crs = 0; repeat (3) tick();
        check(d == 3037, "R2 deferral abort strobe", d, 3037);

        // R3 deferral allowed: no abort, send when carrier drops
        cfg_defer_allow = 1; crs = 1;
        tx_start = 1; tick(); tx_start = 0; byte_stb = 1;
        repeat (3200) tick();
        byte_stb = 0;
        check(exp_q.size() == 0, "R3 no abort while deferring", exp_q.size(), 0);
        exp_q.push_back(EV_SEND); crs = 0;
        @(negedge clk);
        check(send_req == 1'b1, "R3 send on carrier low", int'(send_req), 1);
        tick(); finish_frame(); repeat (3) tick();

        check(exp_q.size() == 0, "R9 all expected events seen", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule